// File: doc/BRIEF.md
# Vector Lane Permute Unit

This block rearranges the lanes of two 128-bit source vectors according to a 32-bit instruction word. It supports four permutations. Transpose-even and transpose-odd pick the even-numbered or odd-numbered element of each lane pair from both sources. Interleave-low and interleave-high alternate elements drawn from the lower or upper half of the sources. Elements can be 8, 16, 32 or 64 bits wide. The operation can run over the full 128-bit vector or over only its low 64 bits.

A caller presents the instruction word and both vectors together with a one-cycle start strobe. One clock later the unit presents the registered result with a one-cycle valid pulse. It also returns the three register numbers taken from the instruction and an illegal flag. The illegal flag marks a word that is not one of the four permutations, or a reserved size/width combination. The result and its side fields are held until the next start.

Top module: `vperm_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `valid_o` and `illegal_o` are 0, and `res_o`, `rd_o`, `rn_o` and `rm_o` are all zero.
- R2: `valid_o` is 1 in exactly the cycle after a cycle with `start_i` high, and 0 otherwise. `res_o`, `illegal_o` and the register fields keep their values when `start_i` is low.
- R3: A word is accepted when it equals 0x0E002800 after bits 30, 23:22, 20:16, 14, 12 and 9:0 are cleared. Bit 30 set means 128-bit width and clear means 64-bit width. Bits 23:22 select the element size: 0 for 8-bit, 1 for 16-bit, 2 for 32-bit, 3 for 64-bit. Bit 12 clear selects transpose and bit 12 set selects interleave. Bit 14 clear selects the even/low form and bit 14 set selects the odd/high form.
- R4: Transpose-even places element 2i of A at result lane 2i and element 2i of B at lane 2i+1. With 32-bit lanes the result is {A0,B0,A2,B2}.
- R5: Transpose-odd places element 2i+1 of A at lane 2i and element 2i+1 of B at lane 2i+1. With 32-bit lanes the result is {A1,B1,A3,B3}.
- R6: Interleave-low fills lanes with A0,B0,A1,B1,... taken from the lower half of the active width.
- R7: Interleave-high fills lanes with alternating elements that start at the middle of the active width. In 64-bit mode this middle is bit 32.
- R8: In 64-bit mode, result bits 127:64 are zero.
- R9: With 64-bit elements at 128-bit width, interleave-low yields {A0,B0} and interleave-high yields {A1,B1}.
- R10: Size 3 with bit 30 clear sets `illegal_o` and gives an all-zero result.
- R11: A word that fails the R3 pattern sets `illegal_o` and gives an all-zero result.
- R12: `rd_o`, `rn_o` and `rm_o` show instruction bits 4:0, 9:5 and 20:16 of the started word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sample the inputs this cycle |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | 128 | First source vector |
| src_b_i | input | 128 | Second source vector |
| res_o | output | 128 | Registered result |
| valid_o | output | 1 | One-cycle pulse when a new result is ready |
| illegal_o | output | 1 | Started word was not executable |
| rd_o | output | 5 | Destination register number |
| rn_o | output | 5 | First source register number |
| rm_o | output | 5 | Second source register number |

## Verification
The assertions assume that `insn_i` and both vectors are stable and known in every cycle where `start_i` is high. They make no assumption about these inputs in other cycles. Start may be raised back to back, and the hold properties take for granted that outputs change only because of a start. The directed stimulus drives inputs and the strobe on the falling edge only. It releases start for at least one cycle between operations, so that the hold behaviour is checked between operations.

// File: rtl/vperm_pkg.sv
package vperm_pkg;
  // {bit14, bit12} of the instruction word
  typedef enum logic [1:0] {
    OP_TRN_EVEN = 2'b00,
    OP_ZIP_LO   = 2'b01,
    OP_TRN_ODD  = 2'b10,
    OP_ZIP_HI   = 2'b11
  } vperm_op_e;

  localparam int          INSN_W     = 32;
  localparam int          REG_W      = 5;
  localparam logic [31:0] INSN_MASK  = 32'hBF20AC00;
  localparam logic [31:0] INSN_MATCH = 32'h0E002800;

  typedef struct packed {
    vperm_op_e        op;
    logic             full;
    logic [1:0]       sz;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rn;
    logic [REG_W-1:0] rm;
    logic             bad;
  } vperm_dec_t;
endpackage

// File: rtl/vperm_decode.sv
module vperm_decode
  import vperm_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output vperm_dec_t        dec_o
);
  logic hit;
  logic rsvd;

  assign hit  = ((insn_i & INSN_MASK) == INSN_MATCH);
  assign rsvd = (insn_i[23:22] == 2'd3) && !insn_i[30];

  always_comb begin
    dec_o.op   = vperm_op_e'({insn_i[14], insn_i[12]});
    dec_o.full = insn_i[30];
    dec_o.sz   = insn_i[23:22];
    dec_o.rd   = insn_i[4:0];
    dec_o.rn   = insn_i[9:5];
    dec_o.rm   = insn_i[20:16];
    dec_o.bad  = !hit || rsvd;
  end
endmodule

// File: rtl/vperm_lanes.sv
module vperm_lanes
  import vperm_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  vperm_op_e        op_i,
  input  logic             full_i,
  input  logic [1:0]       sz_i,
  output logic [VEC_W-1:0] res_o
);
  localparam int NUM_SZ = 4;

  for (genvar gs = 0; gs < NUM_SZ; gs++) begin : g_sz
    localparam int EW = 8 << gs;
    localparam int NL = VEC_W / EW;
    logic [VEC_W-1:0] res_w;

    for (genvar j = 0; j < NL; j++) begin : g_lane
      localparam int TI  = (j / 2) * 2;
      localparam int ZL  = j / 2;
      localparam int ZHF = j / 2 + NL / 2;
      localparam int ZHH = j / 2 + NL / 4;
      logic [VEC_W-1:0] src;
      logic [EW-1:0]    lane;

      if (j % 2 == 0) begin : g_from_a
        assign src = a_i;
      end else begin : g_from_b
        assign src = b_i;
      end

      always_comb begin
        unique case (op_i)
          OP_TRN_EVEN: lane = src[TI*EW +: EW];
          OP_TRN_ODD:  lane = src[(TI+1)*EW +: EW];
          OP_ZIP_LO:   lane = src[ZL*EW +: EW];
          default:     lane = full_i ? src[ZHF*EW +: EW] : src[ZHH*EW +: EW];
        endcase
      end

      assign res_w[j*EW +: EW] = lane;
    end
  end

  always_comb begin
    unique case (sz_i)
      2'd0:    res_o = g_sz[0].res_w;
      2'd1:    res_o = g_sz[1].res_w;
      2'd2:    res_o = g_sz[2].res_w;
      default: res_o = g_sz[3].res_w;
    endcase
  end
endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
  import vperm_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [VEC_W-1:0]  src_a_i,
  input  logic [VEC_W-1:0]  src_b_i,
  output logic [VEC_W-1:0]  res_o,
  output logic              valid_o,
  output logic              illegal_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  rn_o,
  output logic [REG_W-1:0]  rm_o
);
  localparam int HALF_W = VEC_W / 2;

  vperm_dec_t       dec;
  logic [VEC_W-1:0] perm;

  vperm_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  vperm_lanes #(.VEC_W(VEC_W)) u_lanes (
    .a_i    (src_a_i),
    .b_i    (src_b_i),
    .op_i   (dec.op),
    .full_i (dec.full),
    .sz_i   (dec.sz),
    .res_o  (perm)
  );

  // next-state
  logic [VEC_W-1:0] res_d;
  logic             valid_d;
  logic             illegal_d;
  logic [REG_W-1:0] rd_d, rn_d, rm_d;

  always_comb begin
    valid_d   = start_i;
    res_d     = res_o;
    illegal_d = illegal_o;
    rd_d      = rd_o;
    rn_d      = rn_o;
    rm_d      = rm_o;
    if (start_i) begin
      illegal_d = dec.bad;
      rd_d      = dec.rd;
      rn_d      = dec.rn;
      rm_d      = dec.rm;
      if (dec.bad)
        res_d = '0;
      else if (dec.full)
        res_d = perm;
      else
        res_d = {{(VEC_W-HALF_W){1'b0}}, perm[HALF_W-1:0]};
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o     <= '0;
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      rd_o      <= '0;
      rn_o      <= '0;
      rm_o      <= '0;
    end else begin
      valid_o   <= valid_d;
      res_o     <= res_d;
      illegal_o <= illegal_d;
      rd_o      <= rd_d;
      rn_o      <= rn_d;
      rm_o      <= rm_d;
    end
  end

  // R2
  valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o);
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(res_o) && $stable(illegal_o)));
  // R8
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !insn_i[30]) |=> (res_o[VEC_W-1:HALF_W] == '0));
  // R10
  reserved_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && insn_i[23:22] == 2'd3 && !insn_i[30]) |=> illegal_o);
  // R10 R11
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (res_o == '0));
  // R12
  fields_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (rd_o == $past(insn_i[4:0]) && rn_o == $past(insn_i[9:5])
                 && rm_o == $past(insn_i[20:16])));
endmodule

// File: tb/test_vperm_unit.sv
module test_vperm_unit;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [31:0]  insn_i;
  logic [127:0] src_a_i, src_b_i;
  logic [127:0] res_o;
  logic         valid_o, illegal_o;
  logic [4:0]   rd_o, rn_o, rm_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  vperm_unit i_vperm_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .res_o(res_o), .valid_o(valid_o),
    .illegal_o(illegal_o), .rd_o(rd_o), .rn_o(rn_o), .rm_o(rm_o)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // R3 encoding: odd selects bit14, zip selects bit12
  function automatic logic [31:0] mk(bit odd, bit zip, bit q, logic [1:0] sz,
                                     logic [4:0] rd, logic [4:0] rn, logic [4:0] rm);
    return 32'h0E002800 | (32'(q) << 30) | (32'(sz) << 22) | (32'(rm) << 16)
         | (32'(odd) << 14) | (32'(zip) << 12) | (32'(rn) << 5) | 32'(rd);
  endfunction

  function automatic logic [127:0] model(bit odd, bit zip, bit q, logic [1:0] sz,
                                         logic [127:0] a, logic [127:0] b);
    logic [127:0] r = '0;
    int ew = 8 << sz;
    int w  = q ? 128 : 64;
    int n  = w / ew;
    if (sz == 2'd3 && !q) return '0;
    for (int j = 0; j < n; j++) begin
      int k;
      if (!zip) k = (j / 2) * 2 + int'(odd);
      else      k = j / 2 + (odd ? n / 2 : 0);
      for (int t = 0; t < ew; t++)
        r[j*ew+t] = (j % 2 == 0) ? a[k*ew+t] : b[k*ew+t];
    end
    return r;
  endfunction

  // drive on falling edge, result visible at the following falling edge
  task automatic issue(input logic [31:0] w, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    insn_i = w; src_a_i = a; src_b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_op(bit odd, bit zip, bit q, logic [1:0] sz,
                        logic [127:0] a, logic [127:0] b, string req);
    logic [127:0] e;
    e = model(odd, zip, q, sz, a, b);
    issue(mk(odd, zip, q, sz, 5'd1, 5'd2, 5'd3), a, b);
    chk(res_o == e, req, res_o, e);
    chk(valid_o == 1'b1 && illegal_o == 1'b0, {req, "/R2 valid"},
        {126'b0, valid_o, illegal_o}, 128'd2);
  endtask

  logic [127:0] va, vb, vc, vd;

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; insn_i = '0; src_a_i = '0; src_b_i = '0;
    repeat (3) @(negedge clk);
    chk(valid_o == 0 && illegal_o == 0 && res_o == 0, "R1 in reset", res_o, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(valid_o == 0 && illegal_o == 0 && res_o == 0 && rd_o == 0 && rn_o == 0
        && rm_o == 0, "R1 after release", {rd_o, rn_o, rm_o}, '0);
  endtask

  task automatic t_transpose();
    for (int s = 0; s < 4; s++) begin
      run_op(0, 0, 1, 2'(s), va, vb, "R4 trn even full");
      run_op(1, 0, 1, 2'(s), vc, vd, "R5 trn odd full");
      if (s < 3) begin
        run_op(0, 0, 0, 2'(s), vc, vb, "R4 trn even half");
        run_op(1, 0, 0, 2'(s), va, vd, "R5 trn odd half");
      end
    end
    issue(mk(0, 0, 1, 2'd2, 0, 0, 0), va, vb);
    chk(res_o == {vb[95:64], va[95:64], vb[31:0], va[31:0]}, "R4 32-bit literal",
        res_o, {vb[95:64], va[95:64], vb[31:0], va[31:0]});
    issue(mk(1, 0, 1, 2'd2, 0, 0, 0), va, vb);
    chk(res_o == {vb[127:96], va[127:96], vb[63:32], va[63:32]}, "R5 32-bit literal",
        res_o, {vb[127:96], va[127:96], vb[63:32], va[63:32]});
  endtask

  task automatic t_interleave();
    for (int s = 0; s < 4; s++) begin
      run_op(0, 1, 1, 2'(s), va, vb, "R6 zip low full");
      run_op(1, 1, 1, 2'(s), vc, vd, "R7 zip high full");
      if (s < 3) begin
        run_op(0, 1, 0, 2'(s), vd, va, "R6 zip low half");
        run_op(1, 1, 0, 2'(s), va, vb, "R7 zip high half");
      end
    end
    issue(mk(0, 1, 0, 2'd0, 0, 0, 0), va, vb);
    chk(res_o == 128'h2313221221112010, "R6 byte literal", res_o, 128'h2313221221112010);
    issue(mk(1, 1, 0, 2'd2, 0, 0, 0), va, vb);
    chk(res_o == {64'b0, vb[63:32], va[63:32]}, "R7 half uses bits 63:32",
        res_o, {64'b0, vb[63:32], va[63:32]});
  endtask

  task automatic t_dword();
    issue(mk(0, 1, 1, 2'd3, 0, 0, 0), vc, vd);
    chk(res_o == {vd[63:0], vc[63:0]}, "R9 zip low 64", res_o, {vd[63:0], vc[63:0]});
    issue(mk(1, 1, 1, 2'd3, 0, 0, 0), vc, vd);
    chk(res_o == {vd[127:64], vc[127:64]}, "R9 zip high 64", res_o, {vd[127:64], vc[127:64]});
  endtask

  task automatic t_half_zero();
    issue(mk(1, 0, 0, 2'd1, 0, 0, 0), {128{1'b1}}, {128{1'b1}});
    chk(res_o[127:64] == 0 && res_o[63:0] == {64{1'b1}}, "R8 upper zero", res_o,
        {64'b0, {64{1'b1}}});
  endtask

  task automatic t_reserved();
    issue(mk(0, 1, 0, 2'd3, 0, 0, 0), va, vb);
    chk(illegal_o == 1 && res_o == 0 && valid_o == 1, "R10 size3 half", res_o, '0);
    issue(mk(0, 1, 1, 2'd3, 0, 0, 0), va, vb);
    chk(illegal_o == 0, "R10 size3 full legal", {127'b0, illegal_o}, '0);
  endtask

  task automatic t_unmatched();
    issue(32'h0E005800 | (32'd1 << 30), va, vb);
    chk(illegal_o == 1 && res_o == 0, "R11 bit13 clear", res_o, '0);
    issue(mk(0, 0, 1, 2'd0, 0, 0, 0) | 32'h0020_0000, va, vb);
    chk(illegal_o == 1 && res_o == 0, "R11 bit21 set", res_o, '0);
    issue(mk(0, 0, 1, 2'd0, 0, 0, 0) ^ 32'h8000_0000, va, vb);
    chk(illegal_o == 1 && res_o == 0, "R11 bit31 set", res_o, '0);
    issue(mk(0, 0, 1, 2'd0, 0, 0, 0), va, vb);
    chk(illegal_o == 0 && res_o == model(0, 0, 1, 0, va, vb), "R3 legal clears flag",
        res_o, model(0, 0, 1, 0, va, vb));
  endtask

  task automatic t_fields();
    issue(mk(1, 1, 1, 2'd1, 5'd31, 5'd17, 5'd9), va, vb);
    chk(rd_o == 31 && rn_o == 17 && rm_o == 9, "R12 fields", {rd_o, rn_o, rm_o},
        {5'd31, 5'd17, 5'd9});
  endtask

  task automatic t_hold();
    logic [127:0] keep;
    issue(mk(0, 0, 1, 2'd0, 5'd4, 5'd5, 5'd6), va, vb);
    keep = res_o;
    @(negedge clk);
    insn_i = 32'hFFFF_FFFF; src_a_i = vc; src_b_i = vd;
    repeat (2) @(negedge clk);
    chk(valid_o == 0 && res_o == keep && illegal_o == 0 && rd_o == 4, "R2 hold",
        res_o, keep);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      va[i*8 +: 8] = 8'h10 + 8'(i);
      vb[i*8 +: 8] = 8'h20 + 8'(i);
      vc[i*8 +: 8] = 8'(i * 37 + 5);
      vd[i*8 +: 8] = 8'(i * 91 + 200);
    end
    t_reset();
    t_transpose();
    t_interleave();
    t_dword();
    t_half_zero();
    t_reserved();
    t_unmatched();
    t_fields();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule